// File: doc/BRIEF.md
# Two-Level Interrupt Entry Sequencer

This block is the interrupt front end of a small 8-bit processor core. It watches two active-low request lines: a maskable request that is sensed as a level, and a non-maskable request that is caught on its falling edge and held until serviced. The core pulses `boundary` whenever it has finished an instruction. At that moment the block decides whether an interrupt is taken. The non-maskable request always wins. The maskable request counts only while the disable flag in the status byte is clear.

Once an interrupt is accepted, the block captures the program counter, status byte and stack pointer. It then drives a synchronous memory port through a fixed entry sequence: two idle cycles, three stack pushes and two vector reads. After that it presents the new program counter, the status byte with its disable flag set, and the adjusted stack pointer for one cycle on `load_valid`. The core also pulses `rti_start` when it decodes a return from interrupt. The block then pops the status byte and the program counter and hands them back in the same way.

The memory port has a fixed read latency of one cycle and no back-pressure. The result on `load_valid` is a one-cycle strobe without a ready signal, and the core must take it in that cycle. The A, X and Y registers are outside this block.

Top module: `int_entry_seq`

## Requirements
- R1: After reset, and whenever `busy` is low, `mem_we`, `mem_re` and `load_valid` are low, and the port never reads and writes in the same cycle.
- R2: A sequence starts only in a cycle where `boundary` (entry) or `rti_start` (return, honoured only when `boundary` is low) is sampled high while idle. A boundary with no qualifying request starts nothing.
- R3: Entry pushes PC[15:8] to 0x0100+SP, then PC[7:0] to 0x0100+SP-1, then the captured status byte to 0x0100+SP-2, in consecutive cycles.
- R4: Entry for the maskable request reads the handler low byte at 0xFFFE and then the high byte at 0xFFFF. `load_valid` rises exactly 8 cycles after the accepting edge's driving half-cycle, with `pc_out` = {high, low}.
- R5: Entry for the non-maskable request uses 0xFFFA (low) and 0xFFFB (high) instead.
- R6: With status bit 2 (disable flag) set, a low `irq_n` is ignored at a boundary. If it stays low, it is taken at a later boundary where bit 2 is clear.
- R7: A pending non-maskable request is taken even with bit 2 set, and it takes precedence over a simultaneous maskable request.
- R8: A falling edge of `nmi_n` is serviced once. Holding `nmi_n` low does not cause a second entry, and the pending mark clears when that entry is accepted.
- R9: The pushed status byte is the pre-entry value. On `load_valid` after entry, `p_out` equals it with bit 2 set, and `sp_out` = SP-3.
- R10: A return reads 0x0100+SP+1 (status), then +2 (PC low), then +3 (PC high). `load_valid` comes 4 cycles after the request, with `p_out`, `pc_out` and `sp_out` = SP+3.
- R11: A falling edge of `nmi_n` that arrives while a sequence is running is kept and serviced at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | 1 | Maskable request, active low, level |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge |
| boundary | input | 1 | Core finished an instruction; decide now |
| rti_start | input | 1 | Core decoded a return from interrupt |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte (bit 2 = disable flag) |
| sp_in | input | 8 | Current stack pointer |
| busy | output | 1 | A sequence is running (through the load cycle) |
| load_valid | output | 1 | One-cycle strobe: core loads pc_out, p_out, sp_out |
| pc_out | output | 16 | New program counter |
| p_out | output | 8 | New status byte |
| sp_out | output | 8 | New stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe; data returns next cycle |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_re |

## Verification
The assertions assume the core raises `boundary` or `rti_start` only while `busy` is low. They also assume the memory answers every read exactly one cycle later. The bench drives these pulses only from an idle state, one cycle wide, and its memory model registers read data on the edge that samples `mem_re`. The assertions further assume that a non-maskable edge is given at least one clock before the boundary that should see it. The bench therefore releases each `nmi_n` pulse a cycle or more ahead of the boundary.

// File: rtl/int_seq_pkg.sv
package int_seq_pkg;
  typedef enum logic [1:0] {
    K_IRQ = 2'd0,
    K_NMI = 2'd1,
    K_RTI = 2'd2
  } seq_kind_e;

  typedef enum logic [3:0] {
    S_IDLE   = 4'd0,
    S_WAIT   = 4'd1,
    S_PUSH_H = 4'd2,
    S_PUSH_L = 4'd3,
    S_PUSH_P = 4'd4,
    S_VEC_L  = 4'd5,
    S_VEC_H  = 4'd6,
    S_POP_P  = 4'd7,
    S_POP_L  = 4'd8,
    S_POP_H  = 4'd9,
    S_LOAD   = 4'd10
  } seq_state_e;
endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic clear,
  output logic pending
);
  logic prev_q;
  logic fall;

  assign fall = prev_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b1;
      pending <= 1'b0;
    end else begin
      prev_q <= nmi_n;
      // a new edge beats a clear in the same cycle so it is never lost
      if (fall)       pending <= 1'b1;
      else if (clear) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/int_arbiter.sv
module int_arbiter (
  input  logic nmi_pend,
  input  logic irq_n,
  input  logic mask_flag,
  output logic take,
  output logic take_nmi
);
  logic irq_ok;

  assign irq_ok   = ~irq_n & ~mask_flag;
  assign take_nmi = nmi_pend;
  assign take     = nmi_pend | irq_ok;
endmodule

// File: rtl/int_seq_fsm.sv
module int_seq_fsm
  import int_seq_pkg::*;
#(
  parameter int          PC_W     = 16,
  parameter int          D_W      = 8,
  parameter int          IDLE_CYC = 2,
  parameter int          I_BIT    = 2,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [7:0]  STACK_HI = 8'h01
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_int,
  input  logic            start_nmi,
  input  logic            start_rti,
  input  logic [PC_W-1:0] pc_in,
  input  logic [D_W-1:0]  p_in,
  input  logic [D_W-1:0]  sp_in,
  input  logic [D_W-1:0]  mem_rdata,
  output logic            busy,
  output logic            load_valid,
  output logic [PC_W-1:0] pc_out,
  output logic [D_W-1:0]  p_out,
  output logic [D_W-1:0]  sp_out,
  output logic [PC_W-1:0] mem_addr,
  output logic            mem_we,
  output logic            mem_re,
  output logic [D_W-1:0]  mem_wdata
);
  localparam int CW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(IDLE_CYC - 1);
  localparam logic [D_W-1:0] IMASK = D_W'(1) << I_BIT;
  localparam logic [D_W-1:0] ONE = D_W'(1);
  localparam logic [D_W-1:0] TWO = D_W'(2);
  localparam logic [D_W-1:0] THREE = D_W'(3);

  seq_state_e      state_q, state_d;
  seq_kind_e       kind_q;
  logic [CW-1:0]   wcnt_q;
  logic [PC_W-1:0] pc_q;
  logic [D_W-1:0]  p_q;
  logic [D_W-1:0]  sp_q;
  logic [D_W-1:0]  lo_q;
  logic [PC_W-1:0] vec_base;

  assign vec_base = (kind_q == K_NMI) ? NMI_VEC : IRQ_VEC;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (start_int) state_d = S_WAIT;
                else if (start_rti) state_d = S_POP_P;
      S_WAIT:   if (wcnt_q == WAIT_LAST) state_d = S_PUSH_H;
      S_PUSH_H: state_d = S_PUSH_L;
      S_PUSH_L: state_d = S_PUSH_P;
      S_PUSH_P: state_d = S_VEC_L;
      S_VEC_L:  state_d = S_VEC_H;
      S_VEC_H:  state_d = S_LOAD;
      S_POP_P:  state_d = S_POP_L;
      S_POP_L:  state_d = S_POP_H;
      S_POP_H:  state_d = S_LOAD;
      S_LOAD:   state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      kind_q  <= K_IRQ;
      wcnt_q  <= '0;
      pc_q    <= '0;
      p_q     <= '0;
      sp_q    <= '0;
      lo_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && (start_int || start_rti)) begin
        pc_q   <= pc_in;
        p_q    <= p_in;
        sp_q   <= sp_in;
        wcnt_q <= '0;
        if (start_int) kind_q <= start_nmi ? K_NMI : K_IRQ;
        else           kind_q <= K_RTI;
      end
      if (state_q == S_WAIT) wcnt_q <= wcnt_q + CW'(1);
      // read data lands one cycle after its request
      if (state_q == S_VEC_H) lo_q <= mem_rdata;
      if (state_q == S_POP_L) p_q  <= mem_rdata;
      if (state_q == S_POP_H) lo_q <= mem_rdata;
    end
  end

  always_comb begin
    mem_addr  = '0;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      S_PUSH_H: begin
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp_q};
        mem_wdata = pc_q[PC_W-1:PC_W-D_W];
      end
      S_PUSH_L: begin
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp_q - ONE};
        mem_wdata = pc_q[D_W-1:0];
      end
      S_PUSH_P: begin
        mem_we    = 1'b1;
        mem_addr  = {STACK_HI, sp_q - TWO};
        mem_wdata = p_q;
      end
      S_VEC_L: begin
        mem_re   = 1'b1;
        mem_addr = vec_base;
      end
      S_VEC_H: begin
        mem_re   = 1'b1;
        mem_addr = vec_base + PC_W'(1);
      end
      S_POP_P: begin
        mem_re   = 1'b1;
        mem_addr = {STACK_HI, sp_q + ONE};
      end
      S_POP_L: begin
        mem_re   = 1'b1;
        mem_addr = {STACK_HI, sp_q + TWO};
      end
      S_POP_H: begin
        mem_re   = 1'b1;
        mem_addr = {STACK_HI, sp_q + THREE};
      end
      default: ;
    endcase
  end

  assign busy       = (state_q != S_IDLE);
  assign load_valid = (state_q == S_LOAD);

  always_comb begin
    pc_out = '0;
    p_out  = '0;
    sp_out = '0;
    if (state_q == S_LOAD) begin
      pc_out = {mem_rdata, lo_q};
      if (kind_q == K_RTI) begin
        p_out  = p_q;
        sp_out = sp_q + THREE;
      end else begin
        // disable flag set only after the unmodified byte went to the stack
        p_out  = p_q | IMASK;
        sp_out = sp_q - THREE;
      end
    end
  end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq #(
  parameter int          IDLE_CYC = 2,
  parameter int          I_BIT    = 2,
  parameter logic [15:0] IRQ_VEC  = 16'hFFFE,
  parameter logic [15:0] NMI_VEC  = 16'hFFFA,
  parameter logic [7:0]  STACK_HI = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irq_n,
  input  logic        nmi_n,
  input  logic        boundary,
  input  logic        rti_start,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  input  logic [7:0]  sp_in,
  output logic        busy,
  output logic        load_valid,
  output logic [15:0] pc_out,
  output logic [7:0]  p_out,
  output logic [7:0]  sp_out,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic        mem_re,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  logic nmi_pend;
  logic take, take_nmi;
  logic start_int, start_rti;

  assign start_int = boundary & take & ~busy;
  assign start_rti = rti_start & ~boundary & ~busy;

  nmi_edge_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_n   (nmi_n),
    .clear   (start_int & take_nmi),
    .pending (nmi_pend)
  );

  int_arbiter u_arb (
    .nmi_pend  (nmi_pend),
    .irq_n     (irq_n),
    .mask_flag (p_in[I_BIT]),
    .take      (take),
    .take_nmi  (take_nmi)
  );

  int_seq_fsm #(
    .PC_W     (16),
    .D_W      (8),
    .IDLE_CYC (IDLE_CYC),
    .I_BIT    (I_BIT),
    .IRQ_VEC  (IRQ_VEC),
    .NMI_VEC  (NMI_VEC),
    .STACK_HI (STACK_HI)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_int  (start_int),
    .start_nmi  (take_nmi),
    .start_rti  (start_rti),
    .pc_in      (pc_in),
    .p_in       (p_in),
    .sp_in      (sp_in),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .load_valid (load_valid),
    .pc_out     (pc_out),
    .p_out      (p_out),
    .sp_out     (sp_out),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata)
  );
endmodule

// File: rtl/int_entry_seq_chk.sv
module int_entry_seq_chk #(
  parameter logic [7:0] STACK_HI = 8'h01
) (
  input logic        clk,
  input logic        rst_n,
  input logic        boundary,
  input logic        rti_start,
  input logic        busy,
  input logic        load_valid,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr
);
  a_r1_port_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !load_valid));

  a_r2_start_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(boundary || rti_start));

  a_r3_push_in_stack_page: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] == STACK_HI));

  a_r4_vector_near_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && mem_addr[15:8] != STACK_HI) |-> (mem_addr[15:3] == 13'h1FFF));

  a_r10_load_ends_sequence: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !busy);
endmodule

bind int_entry_seq int_entry_seq_chk #(.STACK_HI(STACK_HI)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .boundary   (boundary),
  .rti_start  (rti_start),
  .busy       (busy),
  .load_valid (load_valid),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_addr   (mem_addr)
);

// File: tb/int_entry_seq_tb_top.sv
module int_entry_seq_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, irq_n, nmi_n, boundary, rti_start;
  logic [15:0] pc_in;
  logic [7:0]  p_in, sp_in, mem_rdata;
  logic        busy, load_valid, mem_we, mem_re;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  p_out, sp_out, mem_wdata;

  int_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .boundary(boundary), .rti_start(rti_start),
    .pc_in(pc_in), .p_in(p_in), .sp_in(sp_in),
    .busy(busy), .load_valid(load_valid),
    .pc_out(pc_out), .p_out(p_out), .sp_out(sp_out),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  // memory model: stack page plus top-of-memory vector bytes, 1-cycle read
  logic [7:0] stk [0:255];
  logic [7:0] vec [0:7];
  always @(posedge clk) begin
    if (mem_we) stk[mem_addr[7:0]] <= mem_wdata;
    if (mem_re)
      mem_rdata <= (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                   (mem_addr[15:3] == 13'h1FFF) ? vec[mem_addr[2:0]] : 8'hEE;
  end

  // access log
  logic        log_clr = 1'b0;
  logic [15:0] wa [0:3];
  logic [7:0]  wd [0:3];
  logic [15:0] ra [0:3];
  int wn = 0, rn = 0;
  always @(posedge clk) begin
    if (log_clr) begin
      wn <= 0; rn <= 0;
    end else begin
      if (mem_we) begin
        if (wn < 4) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
        wn <= wn + 1;
      end
      if (mem_re) begin
        if (rn < 4) ra[rn] <= mem_addr;
        rn <= rn + 1;
      end
    end
  end

  int          lat;
  logic        got, saw_busy;
  logic [15:0] gpc;
  logic [7:0]  gp, gsp;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic bd, input logic rt, input logic [15:0] pc,
                     input logic [7:0] p, input logic [7:0] sp);
    @(negedge clk);
    log_clr = 1'b1; boundary = bd; rti_start = rt;
    pc_in = pc; p_in = p; sp_in = sp;
    @(negedge clk);
    log_clr = 1'b0; boundary = 1'b0; rti_start = 1'b0;
    got = 1'b0; saw_busy = busy; lat = 0;
    if (load_valid) begin got = 1'b1; lat = 1; gpc = pc_out; gp = p_out; gsp = sp_out; end
    for (int k = 2; k <= 14; k++) begin
      @(negedge clk);
      if (busy) saw_busy = 1'b1;
      if (load_valid && !got) begin
        got = 1'b1; lat = k; gpc = pc_out; gp = p_out; gsp = sp_out;
      end
    end
  endtask

  task automatic nmi_pulse();
    @(negedge clk); nmi_n = 1'b0;
    @(negedge clk); nmi_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 load_valid after reset", load_valid, 0);
    chk("R1 port idle after reset", {mem_we, mem_re}, 0);
  endtask

  task automatic t_no_request();
    run(1'b1, 1'b0, 16'h2000, 8'h20, 8'hFD);
    chk("R2 no start without request", saw_busy, 0);
    chk("R1 no access without request", wn + rn, 0);
  endtask

  task automatic t_irq_entry();
    irq_n = 1'b0;
    run(1'b1, 1'b0, 16'h1234, 8'h20, 8'hFD);
    irq_n = 1'b1;
    chk("R3 push count", wn, 3);
    chk("R3 push PCH addr", wa[0], 16'h01FD);
    chk("R3 push PCH data", wd[0], 8'h12);
    chk("R3 push PCL addr", wa[1], 16'h01FC);
    chk("R3 push PCL data", wd[1], 8'h34);
    chk("R3 push P addr", wa[2], 16'h01FB);
    chk("R9 pushed P is pre-entry", wd[2], 8'h20);
    chk("R4 vector low addr", ra[0], 16'hFFFE);
    chk("R4 vector high addr", ra[1], 16'hFFFF);
    chk("R4 load latency", lat, 8);
    chk("R4 handler pc", gpc, 16'h8000);
    chk("R9 p_out disable set", gp, 8'h24);
    chk("R9 sp_out", gsp, 8'hFA);
  endtask

  task automatic t_rti();
    run(1'b0, 1'b1, 16'h0000, 8'h24, 8'hFA);
    chk("R10 read count", rn, 3);
    chk("R10 pop P addr", ra[0], 16'h01FB);
    chk("R10 pop PCL addr", ra[1], 16'h01FC);
    chk("R10 pop PCH addr", ra[2], 16'h01FD);
    chk("R10 latency", lat, 4);
    chk("R10 restored pc", gpc, 16'h1234);
    chk("R10 restored p", gp, 8'h20);
    chk("R10 restored sp", gsp, 8'hFD);
  endtask

  task automatic t_irq_masked();
    irq_n = 1'b0;
    run(1'b1, 1'b0, 16'h3000, 8'h24, 8'hFD);
    chk("R6 masked irq ignored", saw_busy, 0);
    chk("R6 masked irq no writes", wn, 0);
    run(1'b1, 1'b0, 16'h3002, 8'h20, 8'hFD);
    irq_n = 1'b1;
    chk("R6 held irq taken once unmasked", got, 1);
    chk("R6 unmasked vector", gpc, 16'h8000);
  endtask

  task automatic t_nmi_masked_flag();
    nmi_pulse();
    run(1'b1, 1'b0, 16'h4321, 8'h24, 8'hF0);
    chk("R7 nmi taken with flag set", got, 1);
    chk("R5 nmi vector low addr", ra[0], 16'hFFFA);
    chk("R5 nmi vector high addr", ra[1], 16'hFFFB);
    chk("R5 nmi handler pc", gpc, 16'h9000);
    chk("R9 nmi pushed P", wd[2], 8'h24);
    chk("R9 nmi sp_out", gsp, 8'hED);
  endtask

  task automatic t_nmi_priority();
    irq_n = 1'b0;
    nmi_pulse();
    run(1'b1, 1'b0, 16'h5000, 8'h20, 8'hFD);
    chk("R7 nmi wins over irq", gpc, 16'h9000);
    run(1'b1, 1'b0, 16'h5010, 8'h20, 8'hFD);
    irq_n = 1'b1;
    chk("R8 pending cleared, irq next", gpc, 16'h8000);
  endtask

  task automatic t_nmi_held();
    @(negedge clk); nmi_n = 1'b0;
    @(negedge clk);
    run(1'b1, 1'b0, 16'h6000, 8'h20, 8'hFD);
    chk("R8 held nmi first entry", gpc, 16'h9000);
    run(1'b1, 1'b0, 16'h6004, 8'h20, 8'hFD);
    chk("R8 held nmi not retaken", saw_busy, 0);
    nmi_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_nmi_while_busy();
    irq_n = 1'b0;
    fork
      run(1'b1, 1'b0, 16'h7000, 8'h20, 8'hFD);
      begin
        repeat (4) @(negedge clk);
        irq_n = 1'b1;
        nmi_n = 1'b0;
        @(negedge clk); nmi_n = 1'b1;
      end
    join
    chk("R11 first entry is irq", gpc, 16'h8000);
    run(1'b1, 1'b0, 16'h7100, 8'h24, 8'hFD);
    chk("R11 edge during busy kept", got, 1);
    chk("R11 kept edge uses nmi vector", gpc, 16'h9000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    vec[0] = 8'h11; vec[1] = 8'h22; vec[2] = 8'h00; vec[3] = 8'h90;
    vec[4] = 8'h33; vec[5] = 8'h44; vec[6] = 8'h00; vec[7] = 8'h80;
    rst_n = 1'b0; irq_n = 1'b1; nmi_n = 1'b1; boundary = 1'b0; rti_start = 1'b0;
    pc_in = '0; p_in = '0; sp_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_request();
    t_irq_entry();
    t_rti();
    t_irq_masked();
    t_nmi_masked_flag();
    t_nmi_priority();
    t_nmi_held();
    t_nmi_while_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule